// File: doc/BRIEF.md
# Serial Flash Power-On Sequencer

This block takes the internal state of a serial NOR flash device from the moment the supply comes up to the point where the device is fully usable. An external comparator reports whether the supply is above the power-on threshold. The block passes that flag through a two-flop synchronizer. While the flag is low, every register is held cleared. Once the flag rises, the block opens a startup window whose length comes from a delay input. During that window only the two status-read instructions get through, and the busy bit is held high. When the window closes, the block settles into standby. At that point the busy and write-enable bits are clear, every sector's lock pair is clear, and the serial protocol mode is loaded from the nonvolatile configuration field.

Instructions reach the block as a decoded opcode, an argument and a single-cycle valid strobe. The command path has no ready and never applies back-pressure. Every valid strobe gets exactly one answer, one clock later: either an accept pulse or a reject pulse. The upstream decoder must treat a reject as a dropped instruction. Once the device is ready, the block also keeps the write-enable latch and a write-lock/lock-down bit pair for each sector. A drop of the supply below the threshold returns everything to the cleared state at once.

Top module: `pwrup_ctrl`

## Requirements
- R1: While the synchronized supply flag is low (or rst_n is low), no instruction is accepted. A valid strobe that arrives when rst_n is high but the supply flag is low produces a reject pulse. In that state wip_o, wel_o, standby_o and all lock bits are 0, and mode_o is 2'b00.
- R2: During the startup window, only opcodes 8'h05 (status read) and 8'h70 (flag-status read) are accepted. Every other valid opcode is rejected.
- R3: Throughout the startup window, wip_o is 1 and wel_o is 0. The write-enable opcode 8'h06 is rejected there and leaves wel_o at 0.
- R4: wip_o rises on the third clock edge after supply_ok_i rises: two synchronizer edges, then one state edge. The window lasts delay_i+1 cycles. delay_i is captured on entry to the window, so later changes to it have no effect.
- R5: When the window ends, wip_o falls, standby_o rises, wel_o is 0, and every lock_wr_o and lock_dn_o bit is 0.
- R6: On entry to standby, mode_o takes the nonvolatile field: 00 extended, 01 dual, 10 quad, and 11 is treated as 00. Later changes to nv_mode_i have no effect until the next power-up.
- R7: If supply_ok_i falls at any time, standby_o, wip_o, wel_o, mode_o and all lock bits are 0 by the third clock edge after the fall. A startup window that is in progress is abandoned.
- R8: In standby, every opcode is accepted except a lock write whose conditions fail. 8'h06 sets wel_o and 8'h04 clears it.
- R9: The lock-write opcode is 8'hE5. Its argument is laid out as follows: bit 0 is the new write-lock bit, bit 1 is the new lock-down bit, and bits [ARG_W-1:2] are the sector index. The write is accepted only if all three of these hold: wel_o is 1, the sector index is below NSECT, and that sector's lock-down bit is 0. An accepted write updates the sector's pair and clears wel_o. A rejected write changes nothing.
- R10: accept_o and reject_o are single-cycle pulses that appear exactly one cycle after a valid strobe. They are never high together, and neither is high without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| supply_ok_i | input | 1 | Supply above power-on threshold flag (asynchronous to clk) |
| delay_i | input | CNT_W | Startup window length minus one, in cycles |
| op_valid_i | input | 1 | Single-cycle instruction strobe |
| op_code_i | input | 8 | Decoded instruction opcode |
| op_arg_i | input | ARG_W | Instruction argument (sector and lock pair for lock writes) |
| nv_mode_i | input | 2 | Protocol field of the nonvolatile configuration |
| accept_o | output | 1 | Instruction accepted (one cycle after strobe) |
| reject_o | output | 1 | Instruction rejected (one cycle after strobe) |
| wip_o | output | 1 | Write-in-progress status bit |
| wel_o | output | 1 | Write-enable latch status bit |
| lock_wr_o | output | NSECT | Per-sector write-lock bits |
| lock_dn_o | output | NSECT | Per-sector lock-down bits |
| mode_o | output | 2 | Active protocol mode |
| standby_o | output | 1 | Device powered up and idle in standby |

## Verification
The bench goes after each of the following corner cases:
- It measures the exact startup latency and window length, and changes delay_i mid-window. A sequencer that re-reads the delay, or that skips a synchronizer stage, would give the wrong count.
- It sends write-enable and lock-write opcodes inside the window. A filter that let them through would raise wel_o while wip_o is high.
- It covers the lock path: a lock write with the latch clear, a write to a locked-down sector, and a sector index beyond NSECT. Each of these must be refused with no state change; a design that checked only the latch would corrupt a frozen pair.
- It drops the supply both in standby and mid-window. Any register left outside the clear would show stale locks, stale mode or a late standby. The reserved mode code is also checked to map to extended.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    PU_OFF   = 2'd0,
    PU_WAIT  = 2'd1,
    PU_READY = 2'd2
  } pu_state_e;

  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_RD_FLAG   = 8'h70;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_WR_LOCK   = 8'hE5;

  function automatic logic is_poll_op(input logic [7:0] op);
    return (op == OP_RD_STATUS) || (op == OP_RD_FLAG);
  endfunction

  // reserved code falls back to extended single-line mode
  function automatic logic [1:0] mode_norm(input logic [1:0] f);
    return (f == 2'b11) ? 2'b00 : f;
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_i,
  input  logic [CNT_W-1:0] delay_i,
  output pu_state_e        state_o,
  output logic             enter_ready_o
);
  pu_state_e        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PU_OFF;
      cnt   <= '0;
    end else if (!sup_i) begin
      state <= PU_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        PU_OFF: begin
          state <= PU_WAIT;
          cnt   <= delay_i;
        end
        PU_WAIT: begin
          if (cnt == '0) state <= PU_READY;
          else           cnt   <= cnt - 1'b1;
        end
        PU_READY: state <= PU_READY;
        default:  state <= PU_OFF;
      endcase
    end
  end

  assign state_o       = state;
  assign enter_ready_o = sup_i && (state == PU_WAIT) && (cnt == '0);

  // R7: a low supply flag forces the off state on the next edge
  a_r7_drop_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_i |=> state == PU_OFF);
  // R4: the window is never skipped
  a_r4_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    state == PU_OFF |=> state != PU_READY);
endmodule

// File: rtl/pwrup_cmd_gate.sv
module pwrup_cmd_gate
  import pwrup_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int SEC_W = 3,
  parameter int ARG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_i,
  input  pu_state_e        state_i,
  input  logic             op_valid_i,
  input  logic [7:0]       op_code_i,
  input  logic [ARG_W-1:0] op_arg_i,
  input  logic             wel_i,
  input  logic [NSECT-1:0] lock_dn_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic             wel_set_o,
  output logic             wel_clr_o,
  output logic             lk_we_o,
  output logic [SEC_W-1:0] lk_sec_o,
  output logic [1:0]       lk_val_o
);
  logic             live_wait, live_ready;
  logic [SEC_W-1:0] sec;
  logic             sec_ok, dn_hit, lock_ok, is_lock, grant;

  assign live_wait  = sup_i && (state_i == PU_WAIT);
  assign live_ready = sup_i && (state_i == PU_READY);
  assign sec        = op_arg_i[ARG_W-1:2];
  assign sec_ok     = 32'(sec) < NSECT;
  assign is_lock    = op_code_i == OP_WR_LOCK;

  always_comb begin
    dn_hit = 1'b0;
    for (int i = 0; i < NSECT; i++)
      if (SEC_W'(i) == sec) dn_hit = lock_dn_i[i];
  end

  assign lock_ok = wel_i && sec_ok && !dn_hit;

  always_comb begin
    grant = 1'b0;
    if (op_valid_i) begin
      if (live_wait)       grant = is_poll_op(op_code_i);
      else if (live_ready) grant = !is_lock || lock_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      accept_o <= grant;
      reject_o <= op_valid_i && !grant;
    end
  end

  assign wel_set_o = grant && live_ready && (op_code_i == OP_WR_EN);
  assign wel_clr_o = grant && live_ready && ((op_code_i == OP_WR_DIS) || is_lock);
  assign lk_we_o   = grant && live_ready && is_lock;
  assign lk_sec_o  = sec;
  assign lk_val_o  = op_arg_i[1:0];

  // R2: only the two polling reads pass during the window
  a_r2_wait_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_i && state_i == PU_WAIT && op_valid_i && !is_poll_op(op_code_i))
      |=> reject_o && !accept_o);
  // R1: nothing is accepted while off
  a_r1_off_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == PU_OFF && op_valid_i) |=> reject_o && !accept_o);
  // R10: at most one response per cycle
  a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_o, reject_o}));
  // R10: no response without a strobe
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !accept_o && !reject_o);
endmodule

// File: rtl/pwrup_status.sv
module pwrup_status
  import pwrup_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int SEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_i,
  input  pu_state_e        state_i,
  input  logic             enter_ready_i,
  input  logic [1:0]       nv_mode_i,
  input  logic             wel_set_i,
  input  logic             wel_clr_i,
  input  logic             lk_we_i,
  input  logic [SEC_W-1:0] lk_sec_i,
  input  logic [1:0]       lk_val_i,
  output logic             wel_o,
  output logic [NSECT-1:0] lock_wr_o,
  output logic [NSECT-1:0] lock_dn_o,
  output logic [1:0]       mode_o
);
  logic clr;
  assign clr = !sup_i || (state_i != PU_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wel_o <= 1'b0;
    else if (clr)       wel_o <= 1'b0;
    else if (wel_set_i) wel_o <= 1'b1;
    else if (wel_clr_i) wel_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mode_o <= 2'b00;
    else if (!sup_i || state_i == PU_OFF)   mode_o <= 2'b00;
    else if (enter_ready_i)                 mode_o <= mode_norm(nv_mode_i);
  end

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_wr_o[g] <= 1'b0;
        lock_dn_o[g] <= 1'b0;
      end else if (clr) begin
        lock_wr_o[g] <= 1'b0;
        lock_dn_o[g] <= 1'b0;
      end else if (lk_we_i && lk_sec_i == SEC_W'(g)) begin
        lock_wr_o[g] <= lk_val_i[0];
        lock_dn_o[g] <= lk_val_i[1];
      end
    end

    // R9: a locked-down pair is frozen while standby lasts
    a_r9_down_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_dn_o[g] && sup_i && state_i == PU_READY)
        |=> lock_dn_o[g] && $stable(lock_wr_o[g]));
  end

  // R6: mode holds steady through standby
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == PU_READY && $past(state_i == PU_READY)) |-> $stable(mode_o));
  // R3: latch is never set outside standby
  a_r3_wel_low: assert property (@(posedge clk) disable iff (!rst_n)
    state_i != PU_READY |-> !wel_o);
endmodule

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import pwrup_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NSECT       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEC_W      = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int ARG_W      = SEC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             op_valid_i,
  input  logic [7:0]       op_code_i,
  input  logic [ARG_W-1:0] op_arg_i,
  input  logic [1:0]       nv_mode_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic             wip_o,
  output logic             wel_o,
  output logic [NSECT-1:0] lock_wr_o,
  output logic [NSECT-1:0] lock_dn_o,
  output logic [1:0]       mode_o,
  output logic             standby_o
);
  logic             sup;
  pu_state_e        state;
  logic             enter_ready;
  logic             wel_set, wel_clr, lk_we;
  logic [SEC_W-1:0] lk_sec;
  logic [1:0]       lk_val;

  pwrup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(supply_ok_i), .q_o(sup)
  );

  pwrup_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sup_i(sup), .delay_i(delay_i),
    .state_o(state), .enter_ready_o(enter_ready)
  );

  pwrup_cmd_gate #(.NSECT(NSECT), .SEC_W(SEC_W), .ARG_W(ARG_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .sup_i(sup), .state_i(state),
    .op_valid_i(op_valid_i), .op_code_i(op_code_i), .op_arg_i(op_arg_i),
    .wel_i(wel_o), .lock_dn_i(lock_dn_o),
    .accept_o(accept_o), .reject_o(reject_o),
    .wel_set_o(wel_set), .wel_clr_o(wel_clr),
    .lk_we_o(lk_we), .lk_sec_o(lk_sec), .lk_val_o(lk_val)
  );

  pwrup_status #(.NSECT(NSECT), .SEC_W(SEC_W)) u_status (
    .clk(clk), .rst_n(rst_n), .sup_i(sup), .state_i(state),
    .enter_ready_i(enter_ready), .nv_mode_i(nv_mode_i),
    .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .lk_we_i(lk_we), .lk_sec_i(lk_sec), .lk_val_i(lk_val),
    .wel_o(wel_o), .lock_wr_o(lock_wr_o), .lock_dn_o(lock_dn_o),
    .mode_o(mode_o)
  );

  assign wip_o     = (state == PU_WAIT);
  assign standby_o = (state == PU_READY);

  // R3: busy and write-enabled never coexist
  a_r3_wip_excl: assert property (@(posedge clk) disable iff (!rst_n)
    wip_o |-> !wel_o);
  // R5: standby is entered with every status bit clean
  a_r5_clean_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_o) |-> !wip_o && !wel_o && lock_wr_o == '0 && lock_dn_o == '0);
endmodule

// File: tb/tb_pwrup_ctrl.sv
module tb_pwrup_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int NSECT = 6;
  localparam int ARG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             supply_ok = 1'b0;
  logic [CNT_W-1:0] delay = '0;
  logic             op_valid = 1'b0;
  logic [7:0]       op_code = '0;
  logic [ARG_W-1:0] op_arg = '0;
  logic [1:0]       nv_mode = '0;
  logic             accept, reject, wip, wel, standby;
  logic [NSECT-1:0] lock_wr, lock_dn;
  logic [1:0]       mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit acc; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_ctrl #(.CNT_W(CNT_W), .NSECT(NSECT)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .delay_i(delay),
    .op_valid_i(op_valid), .op_code_i(op_code), .op_arg_i(op_arg),
    .nv_mode_i(nv_mode), .accept_o(accept), .reject_o(reject),
    .wip_o(wip), .wel_o(wel), .lock_wr_o(lock_wr), .lock_dn_o(lock_dn),
    .mode_o(mode), .standby_o(standby)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // driver: one strobe, expected answer pushed to the scoreboard
  task automatic send(input logic [7:0] op, input logic [ARG_W-1:0] arg,
                      input bit exp_acc, input string tag);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_arg = arg;
    e.acc = exp_acc; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor: compare every response pulse with the queue head (R10)
  always @(negedge clk) begin
    if (accept || reject) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "response without strobe", {30'd0, accept, reject}, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(accept == e.acc && reject == !e.acc, e.tag, "accept/reject",
            {30'd0, accept, reject}, e.acc ? 2 : 1);
      end
    end
  end

  task automatic chk_cleared(input string req);
    chk_eq(req, "standby", standby, 0);
    chk_eq(req, "wip", wip, 0);
    chk_eq(req, "wel", wel, 0);
    chk_eq(req, "lock_wr", lock_wr, 0);
    chk_eq(req, "lock_dn", lock_dn, 0);
    chk_eq(req, "mode", mode, 0);
  endtask

  task automatic drop_supply();
    @(negedge clk);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk_cleared("R7");
  endtask

  // power up and measure latency and window length (R4, R5, R6)
  task automatic powerup_count(input int d, input logic [1:0] nv, input int exp_mode);
    int lat, win;
    delay = CNT_W'(d);
    nv_mode = nv;
    @(negedge clk);
    supply_ok = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wip && lat < 20);
    chk_eq("R4", "wip latency", lat, 3);
    delay = 8'hFF;
    win = 1;
    forever begin
      @(negedge clk);
      if (!wip || win > 300) break;
      win++;
    end
    chk_eq("R4", "window length", win, d + 1);
    chk_eq("R5", "standby", standby, 1);
    chk_eq("R5", "wel", wel, 0);
    chk_eq("R5", "locks", {lock_wr, lock_dn}, 0);
    chk_eq("R6", "mode", mode, exp_mode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_cleared("R1");
    send(8'h05, '0, 1'b0, "R1");
    send(8'h06, '0, 1'b0, "R1");
    chk_eq("R1", "wel after 06 while off", wel, 0);

    // startup window with polling and forbidden opcodes
    delay = 8'd40;
    nv_mode = 2'b10;
    @(negedge clk);
    supply_ok = 1'b1;
    n = 0;
    while (!wip && n < 20) begin @(negedge clk); n++; end
    send(8'h05, '0, 1'b1, "R2");
    send(8'h70, '0, 1'b1, "R2");
    send(8'h06, '0, 1'b0, "R3");
    chk_eq("R3", "wel in window", wel, 0);
    chk_eq("R3", "wip in window", wip, 1);
    send(8'hE5, 5'b011_01, 1'b0, "R2");
    send(8'h03, '0, 1'b0, "R2");
    chk_eq("R3", "wel still 0", wel, 0);
    n = 0;
    while (!standby && n < 200) begin @(negedge clk); n++; end
    chk_eq("R5", "wip after window", wip, 0);
    chk_eq("R5", "locks after window", {lock_wr, lock_dn}, 0);
    chk_eq("R6", "mode quad", mode, 2);
    nv_mode = 2'b01;
    repeat (4) @(negedge clk);
    chk_eq("R6", "mode ignores nv change", mode, 2);

    // standby instruction handling and locks
    send(8'h05, '0, 1'b1, "R8");
    send(8'h03, '0, 1'b1, "R8");
    send(8'hE5, 5'b011_01, 1'b0, "R9");
    chk_eq("R9", "lock untouched without wel", lock_wr, 0);
    send(8'h06, '0, 1'b1, "R8");
    chk_eq("R8", "wel set", wel, 1);
    send(8'hE5, 5'b011_01, 1'b1, "R9");
    chk_eq("R9", "lock_wr sector3", lock_wr, 6'b001000);
    chk_eq("R9", "wel cleared by lock write", wel, 0);
    send(8'h06, '0, 1'b1, "R8");
    send(8'hE5, 5'b011_11, 1'b1, "R9");
    chk_eq("R9", "lock_dn sector3", lock_dn, 6'b001000);
    send(8'h06, '0, 1'b1, "R8");
    send(8'hE5, 5'b011_00, 1'b0, "R9");
    chk_eq("R9", "locked-down pair kept", {lock_wr, lock_dn}, 12'b001000_001000);
    chk_eq("R9", "wel kept after reject", wel, 1);
    send(8'hE5, 5'b111_01, 1'b0, "R9");
    chk_eq("R9", "out-of-range sector no change", lock_wr, 6'b001000);
    send(8'hE5, 5'b101_01, 1'b1, "R9");
    chk_eq("R9", "sector5 write", lock_wr, 6'b101000);
    send(8'h06, '0, 1'b1, "R8");
    send(8'h04, '0, 1'b1, "R8");
    chk_eq("R8", "wel cleared by 04", wel, 0);
    send(8'h06, '0, 1'b1, "R8");

    // supply loss in standby
    drop_supply();
    send(8'h05, '0, 1'b0, "R1");

    powerup_count(3, 2'b11, 0);
    drop_supply();
    powerup_count(0, 2'b01, 1);
    drop_supply();

    // supply loss inside the window
    delay = 8'd30;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (6) @(negedge clk);
    chk_eq("R7", "in window before drop", wip, 1);
    drop_supply();
    repeat (50) @(negedge clk);
    chk_eq("R7", "window abandoned", standby, 0);

    repeat (2) @(negedge clk);
    chk_eq("R10", "unanswered strobes", sb_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule